// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a virtual page whose translation has missed in the TLB. It takes a 32-bit effective address, an access kind, the sixteen segment registers and the current table configuration. From these it forms a virtual segment identifier and a group address, and it reads the page table in memory one word at a time over a simple request/response port. It scans the eight entries of the primary group first. If none of them matches, it scans the eight entries of the secondary group, whose address comes from the complemented hash.

On a match, the walker sets the referenced bit, and also the changed bit for a store, in the second word of the entry. It writes that word back to memory, then reports the physical address and the updated word so that the TLB can be refilled. A probe access leaves memory untouched. When neither group holds a match, the walker raises a fault that carries a status word and the effective address.

The table configuration is written as one word. The walker checks that word and applies it only when it is consistent.

Top module: `hpt_walker`

## Requirements
- R1: The segment register is selected by EA[31:28], and its bits [23:0] form the VSID. The primary hash is VSID XOR EA[27:12]; the secondary hash is its bitwise complement. The group address is ((hash AND hashmask) << 6) OR base.
- R2: Within a group, entries lie 8 bytes apart and are read in ascending order, slots 0 to 7. The primary group is scanned before the secondary group. The first entry that matches ends the walk.
- R3: An entry matches when all of the following hold in its first word: bit 31 is set, bits [30:7] equal the VSID, bits [5:0] equal EA[27:22], and bit 6 equals 0 in the primary pass or 1 in the secondary pass.
- R4: On a match, `done` pulses for one cycle. At the same time, `done_pa` holds {second word[31:12], EA[11:0]}, and `done_pte` holds the second word after its update.
- R5: The access kind is encoded as 00 read, 01 write, 10 fetch and 11 probe. Read and fetch set bit 8 (R) of the second word. Write sets bits 8 and 7 (R and C). Probe changes neither bit. For every kind except probe, the updated word is written back to the entry address + 4.
- R6: When neither group holds a match, `fault` pulses for one cycle and `fault_addr` holds the EA. `fault_status` is 0x40000000 for a read, 0x42000000 for a write, and 0 for a fetch or a probe.
- R7: A configuration word has its mask in bits [8:0] and its origin in bits [31:16]. It is accepted only if the mask is a run of ones starting at bit 0 and the origin's low 9 bits share no set bit with the mask. An accepted word sets base = origin << 16 and hashmask = (mask << 10) OR 0x3FF. A rejected word leaves the previous settings in force.
- R8: `busy` is high from the accepted request until the cycle in which `done` or `fault` is raised. While `busy` is high, `req_ready` is low and new requests are ignored.
- R9: A memory request keeps `mem_valid`, `mem_addr` and `mem_we` stable until `mem_ready` is seen. Each read completes on a later `mem_rvalid`; a write completes on its handshake.
- R10: After reset, the walker is idle with `busy`, `done`, `fault` and `mem_valid` low, base = 0 and hashmask = 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Strobe that offers a configuration word |
| cfg_word | input | 32 | Origin in [31:16], mask in [8:0] |
| seg_regs | input | 512 | Sixteen 32-bit segment registers; register i is at [32*i+31:32*i] |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker can take a request |
| req_ea | input | 32 | Effective address to translate |
| req_kind | input | 2 | Access kind (00 read, 01 write, 10 fetch, 11 probe) |
| busy | output | 1 | A walk is in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle pulse on a successful walk |
| done_pa | output | 32 | Physical address |
| done_pte | output | 32 | Updated second entry word |
| fault | output | 1 | One-cycle pulse on a failed walk |
| fault_status | output | 32 | Fault status bits |
| fault_addr | output | 32 | Faulting effective address |

## Verification
The `done` and `fault` pulses are registered. `done` rises one cycle after the accepted write-back, or, for a probe, one cycle after the response that returns the second entry word. `fault` rises one cycle after the response for the last secondary slot. The result words settle in that same cycle. The bench therefore polls on falling clock edges until one of the two pulses appears, and compares `done_pa`, `done_pte`, `fault_status` and `fault_addr` in that cycle only. It reads back memory after the pulse, when the write-back has already been accepted. The `busy`/`req_ready` check is sampled at the falling edge that follows acceptance, while the walk is still issuing reads.

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int NSEG        = 16,
  parameter int GRP_ENTRIES = 8,
  parameter int MASK_BITS   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [31:0]        cfg_word,
  input  logic [NSEG*32-1:0] seg_regs,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_ea,
  input  logic [1:0]         req_kind,
  output logic               busy,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  output logic               done,
  output logic [31:0]        done_pa,
  output logic [31:0]        done_pte,
  output logic               fault,
  output logic [31:0]        fault_status,
  output logic [31:0]        fault_addr
);
  localparam int SEG_W = $clog2(NSEG);
  localparam int IDX_W = $clog2(GRP_ENTRIES);
  localparam int HM_W  = MASK_BITS + 10;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_PR = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_W0, S_RD1, S_W1, S_WB} st_t;

  st_t              st;
  logic [31:0]      ea_q;
  logic [1:0]       kind_q;
  logic [23:0]      vsid_q;
  logic             pass_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      pte_q;
  logic [31:0]      base_q;
  logic [HM_W-1:0]  hmask_q;

  logic [23:0]          hash, hsel;
  logic [31:0]          grp, ent;
  logic                 hit;
  logic [31:0]          upd;
  logic [MASK_BITS-1:0] cmask, cmask_inc;
  logic                 cfg_ok;

  assign hash = vsid_q ^ {8'h00, ea_q[27:12]};
  assign hsel = pass_q ? ~hash : hash;
  assign grp  = ({{(32-HM_W){1'b0}}, hsel[HM_W-1:0] & hmask_q} << 6) | base_q;
  assign ent  = grp + (32'(idx_q) << 3);

  assign hit = mem_rdata[31] && (mem_rdata[30:7] == vsid_q) &&
               (mem_rdata[5:0] == ea_q[27:22]) && (mem_rdata[6] == pass_q);
  assign upd = mem_rdata | ((kind_q == K_PR) ? 32'h0 :
                            (kind_q == K_WR) ? 32'h180 : 32'h100);

  assign cmask     = cfg_word[MASK_BITS-1:0];
  assign cmask_inc = cmask + 1'b1;
  assign cfg_ok    = ((cmask & cmask_inc) == '0) &&
                     ((cfg_word[16 +: MASK_BITS] & cmask) == '0);

  assign busy      = (st != S_IDLE);
  assign req_ready = !busy;
  assign mem_valid = (st == S_RD0) || (st == S_RD1) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_RD0) ? ent : ent + 32'd4;
  assign mem_wdata = pte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ea_q <= '0; kind_q <= '0; vsid_q <= '0; pass_q <= 1'b0; idx_q <= '0; pte_q <= '0;
      base_q <= '0; hmask_q <= {{MASK_BITS{1'b0}}, 10'h3ff};
      done <= 1'b0; done_pa <= '0; done_pte <= '0;
      fault <= 1'b0; fault_status <= '0; fault_addr <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (cfg_load && cfg_ok) begin
        base_q  <= {cfg_word[31:16], 16'h0000};
        hmask_q <= {cmask, 10'h3ff};
      end
      case (st)
        S_IDLE: if (req_valid) begin
          ea_q   <= req_ea;
          kind_q <= req_kind;
          vsid_q <= seg_regs[req_ea[31 -: SEG_W]*32 +: 24];
          pass_q <= 1'b0;
          idx_q  <= '0;
          st     <= S_RD0;
        end
        S_RD0: if (mem_ready) st <= S_W0;
        S_W0: if (mem_rvalid) begin
          if (hit) st <= S_RD1;
          else if (idx_q == IDX_W'(GRP_ENTRIES-1)) begin
            if (pass_q) begin
              fault        <= 1'b1;
              fault_addr   <= ea_q;
              fault_status <= (kind_q == K_WR) ? 32'h4200_0000 :
                              (kind_q == K_RD) ? 32'h4000_0000 : 32'h0;
              st           <= S_IDLE;
            end else begin
              pass_q <= 1'b1;
              idx_q  <= '0;
              st     <= S_RD0;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= S_RD0;
          end
        end
        S_RD1: if (mem_ready) st <= S_W1;
        S_W1: if (mem_rvalid) begin
          pte_q <= upd;
          if (kind_q == K_PR) begin
            done     <= 1'b1;
            done_pa  <= {mem_rdata[31:12], ea_q[11:0]};
            done_pte <= mem_rdata;
            st       <= S_IDLE;
          end else st <= S_WB;
        end
        S_WB: if (mem_ready) begin
          done     <= 1'b1;
          done_pa  <= {pte_q[31:12], ea_q[11:0]};
          done_pte <= pte_q;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);
  p_result_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !busy && !(done && fault));
  p_wb_has_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[8] && mem_addr[2]);
  p_probe_no_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && kind_q == K_PR |-> !mem_we);
  p_store_flt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault && fault_status[25] |-> fault_status[30]);
endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         cfg_load = 1'b0;
  logic [31:0]  cfg_word = '0;
  logic [511:0] seg_regs;
  logic         req_valid = 1'b0, req_ready;
  logic [31:0]  req_ea = '0;
  logic [1:0]   req_kind = '0;
  logic         busy, mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [31:0]  mem_addr, mem_wdata, mem_rdata;
  logic         done, fault;
  logic [31:0]  done_pa, done_pte, fault_status, fault_addr;

  hpt_walker u0 (.clk, .rst_n, .cfg_load, .cfg_word, .seg_regs, .req_valid, .req_ready,
    .req_ea, .req_kind, .busy, .mem_valid, .mem_ready, .mem_we, .mem_addr, .mem_wdata,
    .mem_rvalid, .mem_rdata, .done, .done_pa, .done_pte, .fault, .fault_status, .fault_addr);

  logic [31:0] mem [logic [31:0]];
  logic stall_en = 1'b0;
  int total = 0, bad = 0;
  logic [31:0] tb_base = 32'h0;
  logic [31:0] tb_hm = 32'h3ff;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_ready  <= stall_en ? ~mem_ready : 1'b1;
    if (mem_valid && mem_ready) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      end
    end
  end

  function automatic logic [23:0] vsid_of(logic [31:0] ea);
    return seg_regs[ea[31:28]*32 +: 24];
  endfunction

  function automatic logic [31:0] slot_addr(logic [31:0] ea, logic pass, int slot);
    logic [23:0] h;
    h = vsid_of(ea) ^ {8'h00, ea[27:12]};
    if (pass) h = ~h;
    return ((({8'h00, h}) & tb_hm) << 6 | tb_base) + 32'(slot * 8);
  endfunction

  task automatic put(logic [31:0] ea, logic pass, int slot, logic hbit, logic [31:0] w1);
    logic [31:0] a;
    a = slot_addr(ea, pass, slot);
    mem[a] = {1'b1, vsid_of(ea), hbit, ea[27:22]};
    mem[a + 4] = w1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] ea, logic [1:0] kind);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_res(string tag);
    int n = 0;
    while (!(done || fault) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) chk({tag, " timeout"}, 32'h0, 32'h1);
  endtask

  task automatic cfg(logic [31:0] w);
    @(negedge clk);
    cfg_load = 1'b1; cfg_word = w;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  function automatic logic [31:0] setbits(logic [1:0] kind);
    return (kind == 2'd3) ? 32'h0 : (kind == 2'd1) ? 32'h180 : 32'h100;
  endfunction

  task automatic hit_test(string tag, logic [31:0] ea, logic [1:0] kind, logic pass,
                          int slot, logic [19:0] rpn);
    logic [31:0] w1, exp;
    w1 = {rpn, 12'h05a};
    put(ea, pass, slot, pass, w1);
    issue(ea, kind);
    wait_res(tag);
    exp = w1 | setbits(kind);
    chk({tag, " done"}, {31'h0, done}, 32'h1);
    chk({tag, " pa"}, done_pa, {rpn, ea[11:0]});
    chk({tag, " pte"}, done_pte, exp);
    @(negedge clk);
    chk({tag, " mem"}, mem[slot_addr(ea, pass, slot) + 4], exp);
  endtask

  task automatic miss_test(string tag, logic [31:0] ea, logic [1:0] kind, logic [31:0] st);
    issue(ea, kind);
    wait_res(tag);
    chk({tag, " fault"}, {31'h0, fault}, 32'h1);
    chk({tag, " status"}, fault_status, st);
    chk({tag, " addr"}, fault_addr, ea);
  endtask

  // ea, kind, present, pass, slot, rpn, pad
  localparam logic [63:0] VEC [8] = '{
    {32'h1234_5678, 2'd0, 1'b1, 1'b0, 3'd0, 20'hABCDE, 5'd0},
    {32'h3456_7ABC, 2'd1, 1'b1, 1'b0, 3'd5, 20'h00123, 5'd0},
    {32'h5FFF_F001, 2'd2, 1'b1, 1'b1, 3'd2, 20'hFFFFF, 5'd0},
    {32'h9000_0FFF, 2'd1, 1'b1, 1'b1, 3'd7, 20'h13579, 5'd0},
    {32'hC0DE_0123, 2'd0, 1'b0, 1'b0, 3'd0, 20'h00000, 5'd0},
    {32'hE111_2222, 2'd1, 1'b0, 1'b0, 3'd0, 20'h00000, 5'd0},
    {32'h7ABC_D000, 2'd2, 1'b0, 1'b0, 3'd0, 20'h00000, 5'd0},
    {32'h2000_0004, 2'd3, 1'b1, 1'b0, 3'd3, 20'h2468A, 5'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) seg_regs[i*32 +: 32] = {8'hA5, 24'h001000 + 24'(i * 273)};
    repeat (3) @(negedge clk);
    chk("R10 busy", {31'h0, busy}, 32'h0);
    chk("R10 outs", {29'h0, done, fault, mem_valid}, 32'h0);
    chk("R8 ready at reset", {31'h0, req_ready}, 32'h1);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][29])
        hit_test($sformatf("R1 R4 R5 vec%0d", v), VEC[v][63:32], VEC[v][31:30],
                 VEC[v][28], int'(VEC[v][27:25]), VEC[v][24:5]);
      else
        miss_test($sformatf("R6 vec%0d", v), VEC[v][63:32], VEC[v][31:30],
                  (VEC[v][31:30] == 2'd1) ? 32'h4200_0000 :
                  (VEC[v][31:30] == 2'd0) ? 32'h4000_0000 : 32'h0);
    end

    // R3: H bit must agree with the pass
    put(32'h4444_4444, 1'b0, 1, 1'b1, 32'h11111_05a);
    put(32'h4444_4444, 1'b1, 4, 1'b0, 32'h22222_05a);
    miss_test("R3 hbit", 32'h4444_4444, 2'd0, 32'h4000_0000);

    // R2: primary beats secondary, lower slot beats higher
    put(32'h6123_4000, 1'b0, 6, 1'b0, 32'hAAAAA_05a);
    put(32'h6123_4000, 1'b1, 0, 1'b1, 32'hBBBBB_05a);
    issue(32'h6123_4000, 2'd3); wait_res("R2 pri");
    chk("R2 primary first", done_pa, 32'hAAAAA_000);
    put(32'hB0F0_0ABC, 1'b0, 1, 1'b0, 32'hCCCCC_05a);
    put(32'hB0F0_0ABC, 1'b0, 4, 1'b0, 32'hDDDDD_05a);
    issue(32'hB0F0_0ABC, 2'd3); wait_res("R2 order");
    chk("R2 ascending", done_pa, 32'hCCCCC_ABC);

    // R7: rejected and accepted configuration words
    cfg({16'h0000, 7'h0, 9'h005});
    hit_test("R7 noncontig kept", 32'h8123_4567, 2'd0, 1'b0, 2, 20'h0BEEF);
    cfg({16'h0003, 7'h0, 9'h003});
    hit_test("R7 overlap kept", 32'hD765_4321, 2'd1, 1'b1, 1, 20'h0CAFE);
    cfg({16'h0002, 7'h0, 9'h001});
    tb_base = 32'h0002_0000; tb_hm = 32'h7ff;
    hit_test("R7 accepted", 32'hA7FF_E123, 2'd0, 1'b1, 6, 20'h55555);

    // R8: requests ignored while busy
    put(32'h1357_9000, 1'b1, 7, 1'b1, 32'h77777_05a);
    issue(32'h1357_9000, 2'd0);
    req_valid = 1'b1; req_ea = 32'hF000_0000; req_kind = 2'd1;
    chk("R8 busy", {30'h0, busy, req_ready}, 32'h2);
    @(negedge clk);
    req_valid = 1'b0;
    wait_res("R8");
    chk("R8 first request kept", done_pa, 32'h77777_000);
    @(negedge clk);
    chk("R8 idle after", {31'h0, busy}, 32'h0);

    // R9: stalled memory port
    stall_en = 1'b1;
    hit_test("R9 stall", 32'h2468_ACE0, 2'd1, 1'b0, 3, 20'h98765);
    stall_en = 1'b0;

    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule